// File: doc/BRIEF.md
# Edge-Aligned PWM Compare Channel

This block is a single timer output channel. An internal counter runs from zero up to a programmable period value, or from that period value down to zero, and reloads itself at the end of each pass. Each cycle a comparator checks the running count against a compare value and forms a reference waveform. From that reference an output stage builds the pin level, taking into account the selected polarity and an output enable.

The compare rule depends on the counting direction. A second PWM mode inverts the reference. Some edge cases are fixed by the rules below:
- A compare value above the period keeps the reference asserted for the whole pass.
- A zero compare value while counting up keeps it deasserted.
- While counting down, the reference is always asserted for at least the cycle in which the count equals the compare value, so a 0% duty cycle is not available in that direction.

The block also produces a one-cycle update pulse on each wrap or reload. A sticky compare flag records every match. Software clears the flag by pulsing a clear input.

Top module: `pwm_edge_chan`

## Requirements
- R1: With `dir_down`=0 and `cnt_en`=1, the count rises by one per clock. At the clock edge where the count is greater than or equal to `period`, it goes to 0 instead, so a period of 8 gives 9 counts per pass. `upd_o` is 1 in exactly the cycle in which the wrapped value 0 is shown.
- R2: With `dir_down`=1 and `cnt_en`=1, the count falls by one per clock. At the clock edge where the count is 0, it loads `period`, and `upd_o` is 1 in the cycle that shows the loaded value.
- R3: While `cnt_en`=0 the count holds its value and `upd_o` is 0.
- R4: In mode 1 (`mode_sel`=0) counting up, with `cmp_val` not above `period`, `ref_o` is 1 while count < `cmp_val` and 0 otherwise. With `cmp_val`=0, `ref_o` stays 0 for the whole pass.
- R5: In mode 1 counting down, with `cmp_val` not above `period`, `ref_o` is 0 while count > `cmp_val` and 1 otherwise. It is therefore 1 when the count equals `cmp_val`, including the case `cmp_val`=0.
- R6: In mode 1, if `cmp_val` > `period`, `ref_o` is 1 in every cycle in either direction.
- R7: In mode 2 (`mode_sel`=1), `ref_o` is the inverse of the mode 1 value for the same count, compare value, period and direction.
- R8: With `out_en`=1, `pin_o` equals `ref_o` when `pol_low`=0 (active high) and the inverse of `ref_o` when `pol_low`=1 (active low).
- R9: With `out_en`=0, `pin_o` equals `pol_low`, which is the inactive level.
- R10: `cmp_flag_o` becomes 1 after a clock edge at which `cnt_en`=1 and the count equals `cmp_val`. It then stays 1 until a clock edge with `flag_clr`=1. A set and a clear at the same edge leave the flag at 1.
- R11: While `rst`=1 is sampled at a clock edge, the count goes to 0, and `upd_o` and `cmp_flag_o` go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| mode_sel | input | 1 | 0 = PWM mode 1, 1 = PWM mode 2 (inverted) |
| pol_low | input | 1 | 0 = active-high pin, 1 = active-low pin |
| out_en | input | 1 | Output enable; when 0 the pin shows the inactive level |
| period | input | CNT_W | Auto-reload (period) value |
| cmp_val | input | CNT_W | Compare value |
| flag_clr | input | 1 | Write-one-to-clear pulse for the compare flag |
| ref_o | output | 1 | Reference PWM waveform before polarity |
| pin_o | output | 1 | Polarity-adjusted, enable-gated output pin |
| count_o | output | CNT_W | Current counter value |
| upd_o | output | 1 | One-cycle pulse on wrap or reload |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The hardest situations to reach from the ports are the ones tied to a single cycle. One is a clear pulse that lands on the exact edge where a match sets the flag again. Another is a period that is lowered while the count is already above it, or a direction reversal partway through a pass. The bench keeps its own model of the count and uses it to steer the stimulus: it waits until the modelled count reaches the value it needs, then changes `flag_clr`, `period` or `dir_down` right before that edge. After each such event, every following cycle of `count_o`, `upd_o`, `ref_o`, `pin_o` and `cmp_flag_o` is compared with the model.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        PWM_MODE1 = 1'b0,
        PWM_MODE2 = 1'b1
    } pwm_mode_e;

    // Static configuration of the output stage and comparator
    typedef struct packed {
        cnt_dir_e  dir;
        pwm_mode_e mode;
        logic      pol_low;
        logic      oe;
    } chan_cfg_t;

    // Mode 2 inverts the mode 1 reference
    function automatic logic apply_mode(input logic ref1, input pwm_mode_e mode);
        return (mode == PWM_MODE2) ? ~ref1 : ref1;
    endfunction

    // Pin level: inactive level when disabled, polarity applied otherwise
    function automatic logic drive_pin(input logic refv, input logic pol_low,
                                       input logic oe);
        return oe ? (refv ^ pol_low) : pol_low;
    endfunction

endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cnt_dir_e         dir,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             upd_q, upd_d;

    always_comb begin
        cnt_d = cnt_q;
        upd_d = 1'b0;
        if (en) begin
            if (dir == DIR_UP) begin
                // A count already at or beyond the period wraps at once
                if (cnt_q >= period) begin
                    cnt_d = ZERO;
                    upd_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == ZERO) begin
                    cnt_d = period;
                    upd_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            upd_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            upd_q <= upd_d;
        end
    end

    assign count_o = cnt_q;
    assign upd_o   = upd_q;

endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] period,
    input  cnt_dir_e         dir,
    input  pwm_mode_e        mode,
    output logic             ref_o,
    output logic             match_o
);
    logic over_period;
    logic ref_m1;

    assign over_period = (cmp_val > period);

    always_comb begin
        if (over_period) begin
            // Full-duty regardless of direction
            ref_m1 = 1'b1;
        end else if (dir == DIR_UP) begin
            // Asserted below the threshold; compare of zero never asserts
            ref_m1 = (count < cmp_val);
        end else begin
            // Deasserted above the threshold; equality always asserts
            ref_m1 = !(count > cmp_val);
        end
    end

    assign ref_o   = apply_mode(ref_m1, mode);
    assign match_o = (count == cmp_val);

endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            // A new match outranks a simultaneous clear
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pwm_out.sv
module pwm_out
    import pwm_chan_pkg::*;
(
    input  logic      ref_i,
    input  chan_cfg_t cfg,
    output logic      pin_o
);
    assign pin_o = drive_pin(ref_i, cfg.pol_low, cfg.oe);
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             dir_down,
    input  logic             mode_sel,
    input  logic             pol_low,
    input  logic             out_en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             flag_clr,
    output logic             ref_o,
    output logic             pin_o,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o,
    output logic             cmp_flag_o
);
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] count_w;
    logic             ref_w;
    logic             match_w;

    assign cfg.dir     = cnt_dir_e'(dir_down);
    assign cfg.mode    = pwm_mode_e'(mode_sel);
    assign cfg.pol_low = pol_low;
    assign cfg.oe      = out_en;

    pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .dir     (cfg.dir),
        .period  (period),
        .count_o (count_w),
        .upd_o   (upd_o)
    );

    pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count   (count_w),
        .cmp_val (cmp_val),
        .period  (period),
        .dir     (cfg.dir),
        .mode    (cfg.mode),
        .ref_o   (ref_w),
        .match_o (match_w)
    );

    pwm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cnt_en & match_w),
        .clr_i  (flag_clr),
        .flag_o (cmp_flag_o)
    );

    pwm_out u_out (
        .ref_i (ref_w),
        .cfg   (cfg),
        .pin_o (pin_o)
    );

    assign count_o = count_w;
    assign ref_o   = ref_w;

endmodule

// File: rtl/pwm_edge_chan_chk.sv
module pwm_edge_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             dir_down,
    input logic             mode_sel,
    input logic             pol_low,
    input logic             out_en,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cmp_val,
    input logic             flag_clr,
    input logic             ref_o,
    input logic             pin_o,
    input logic [CNT_W-1:0] count_o,
    input logic             upd_o,
    input logic             cmp_flag_o
);

    a_r1_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_down && count_o >= period) |=> (count_o == '0 && upd_o));

    a_r2_down_reload: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_down && count_o == '0) |=> (count_o == $past(period) && upd_o));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(count_o) && !upd_o));

    a_r4_up_zero_low: assert property (@(posedge clk) disable iff (rst)
        (!dir_down && !mode_sel && cmp_val == '0) |-> !ref_o);

    a_r5_down_floor: assert property (@(posedge clk) disable iff (rst)
        (dir_down && !mode_sel && count_o == cmp_val) |-> ref_o);

    a_r6_over_full: assert property (@(posedge clk) disable iff (rst)
        (cmp_val > period) |-> (ref_o == !mode_sel));

    a_r9_idle_pin: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (pin_o == pol_low));

    a_r10_set: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count_o == cmp_val) |=> cmp_flag_o);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (!(cnt_en && count_o == cmp_val) && flag_clr) |=> !cmp_flag_o);

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !upd_o && !cmp_flag_o));

endmodule

bind pwm_edge_chan pwm_edge_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .dir_down   (dir_down),
    .mode_sel   (mode_sel),
    .pol_low    (pol_low),
    .out_en     (out_en),
    .period     (period),
    .cmp_val    (cmp_val),
    .flag_clr   (flag_clr),
    .ref_o      (ref_o),
    .pin_o      (pin_o),
    .count_o    (count_o),
    .upd_o      (upd_o),
    .cmp_flag_o (cmp_flag_o)
);

// File: tb/pwm_edge_chan_tb.sv
module pwm_edge_chan_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic         dir_down = 1'b0;
    logic         mode_sel = 1'b0;
    logic         pol_low = 1'b0;
    logic         out_en = 1'b1;
    logic [W-1:0] period = 16'd8;
    logic [W-1:0] cmp_val = 16'd4;
    logic         flag_clr = 1'b0;
    logic         ref_o, pin_o, upd_o, cmp_flag_o;
    logic [W-1:0] count_o;

    pwm_edge_chan #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_down(dir_down),
        .mode_sel(mode_sel), .pol_low(pol_low), .out_en(out_en),
        .period(period), .cmp_val(cmp_val), .flag_clr(flag_clr),
        .ref_o(ref_o), .pin_o(pin_o), .count_o(count_o),
        .upd_o(upd_o), .cmp_flag_o(cmp_flag_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [W-1:0] cnt;
        logic         upd;
        logic         flag;
        logic         refv;
        logic         pin;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    // Reference model state, derived from the requirements
    logic [W-1:0] m_cnt = '0;
    logic         m_upd = 1'b0;
    logic         m_flag = 1'b0;

    function automatic logic model_ref();
        logic r1;
        if (cmp_val > period)      r1 = 1'b1;          // R6
        else if (!dir_down)        r1 = (m_cnt < cmp_val);   // R4
        else                       r1 = (m_cnt <= cmp_val);  // R5
        return mode_sel ? ~r1 : r1;                    // R7
    endfunction

    // Driver: advance one clock, update the model, push the expectation
    task automatic tick(input string tag);
        logic [W-1:0] n_cnt;
        logic         n_upd, n_flag;
        exp_t e;
        @(posedge clk);
        if (rst) begin
            n_cnt = '0; n_upd = 1'b0; n_flag = 1'b0;
        end else begin
            n_cnt = m_cnt; n_upd = 1'b0;
            if (cnt_en) begin
                if (!dir_down) begin
                    if (m_cnt >= period) begin n_cnt = '0; n_upd = 1'b1; end
                    else n_cnt = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == '0) begin n_cnt = period; n_upd = 1'b1; end
                    else n_cnt = m_cnt - 16'd1;
                end
            end
            if (cnt_en && m_cnt == cmp_val) n_flag = 1'b1;
            else if (flag_clr)              n_flag = 1'b0;
            else                            n_flag = m_flag;
        end
        m_cnt = n_cnt; m_upd = n_upd; m_flag = n_flag;
        @(negedge clk);
        e.cnt  = m_cnt;
        e.upd  = m_upd;
        e.flag = m_flag;
        e.refv = model_ref();
        e.pin  = out_en ? (e.refv ^ pol_low) : pol_low;   // R8, R9
        e.tag  = tag;
        exp_q.push_back(e);
        #4;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // Monitor: pop expectations and compare against the ports
    always @(negedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (count_o !== cur.cnt) begin
                failures++;
                $display("FAIL %s count actual=%0d expected=%0d", cur.tag, count_o, cur.cnt);
            end else if (upd_o !== cur.upd) begin
                failures++;
                $display("FAIL %s upd actual=%0b expected=%0b", cur.tag, upd_o, cur.upd);
            end else if (cmp_flag_o !== cur.flag) begin
                failures++;
                $display("FAIL %s flag actual=%0b expected=%0b", cur.tag, cmp_flag_o, cur.flag);
            end else if (ref_o !== cur.refv) begin
                failures++;
                $display("FAIL %s ref actual=%0b expected=%0b", cur.tag, ref_o, cur.refv);
            end else if (pin_o !== cur.pin) begin
                failures++;
                $display("FAIL %s pin actual=%0b expected=%0b", cur.tag, pin_o, cur.pin);
            end
        end
    end

    task automatic wait_count(input logic [W-1:0] v, input string tag);
        for (int i = 0; i < 40 && m_cnt != v; i++) tick(tag);
    endtask

    initial begin
        // R11: reset state
        run(3, "R11 reset");
        rst = 1'b0;
        cnt_en = 1'b1;

        // R1 R4: up count, period 8, compare 4
        run(20, "R1 R4 up cmp4");
        cmp_val = 16'd8;
        run(12, "R4 up cmp=period");
        cmp_val = 16'd9;
        run(12, "R6 up cmp>period");
        cmp_val = 16'd0;
        run(12, "R4 up cmp0 low");

        // R1: lower the period while the count is above it
        cmp_val = 16'd2;
        wait_count(16'd7, "R1 approach");
        period = 16'd3;
        run(10, "R1 period lowered");
        period = 16'd8;

        // R2 R5: down count
        dir_down = 1'b1;
        cmp_val = 16'd4;
        run(22, "R2 R5 down cmp4");
        cmp_val = 16'd0;
        run(12, "R5 down cmp0 floor");
        cmp_val = 16'd9;
        run(12, "R6 down cmp>period");

        // R7: mode 2 in both directions
        mode_sel = 1'b1;
        cmp_val = 16'd3;
        run(12, "R7 mode2 down");
        dir_down = 1'b0;
        run(12, "R7 mode2 up");
        cmp_val = 16'd0;
        run(10, "R7 mode2 up cmp0");
        mode_sel = 1'b0;
        cmp_val = 16'd5;

        // R8 R9: polarity and enable
        pol_low = 1'b1;
        run(12, "R8 active low");
        out_en = 1'b0;
        run(10, "R9 disabled low-pol");
        pol_low = 1'b0;
        run(10, "R9 disabled high-pol");
        out_en = 1'b1;

        // R3: counter held
        cnt_en = 1'b0;
        run(6, "R3 hold");
        cnt_en = 1'b1;

        // R10: clear away from a match, then clear on the match edge
        wait_count(16'd7, "R10 set");
        flag_clr = 1'b1;
        tick("R10 clear");
        flag_clr = 1'b0;
        run(2, "R10 cleared");
        wait_count(cmp_val, "R10 approach");
        flag_clr = 1'b1;
        tick("R10 set wins");
        flag_clr = 1'b0;
        run(3, "R10 after");

        // R2 R1: reverse direction mid-pass
        wait_count(16'd3, "R2 approach");
        dir_down = 1'b1;
        run(14, "R2 reversed");
        dir_down = 1'b0;
        run(12, "R1 reversed back");

        // R11: reset mid-run
        rst = 1'b1;
        run(2, "R11 reset again");
        rst = 1'b0;
        run(4, "R1 restart");

        @(negedge clk);
        #5;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule